// File: doc/BRIEF.md
# Dual-Mode Serial Register Control Port

This block is the slave end of a configuration port. An external host reaches a small bank of 8-bit registers over one of two serial buses. In two-wire mode the host uses SCL and an open-drain SDA. The slave recognises its address from a fixed six-bit identifier plus the level of a strapped select pin. The host may write registers or read them back. In three-wire mode the same select pin acts as an active-low chip select, and the host only writes, using a clock and a data line.

The block starts in two-wire mode after reset. The first high-to-low transition of the shared select pin after reset switches it to three-wire mode for good. Every transfer first loads a pointer byte. Bit 7 of that byte turns on auto-increment. Bits 6:0 name a register. A read returns the register the pointer names. The pointer is whatever the last pointer byte, and any auto-increments since then, left behind.

All bus pins pass through two-flop synchronizers into the system clock domain, and edges are detected there. Register contents are shown continuously on a flat parallel output. These pins are plain control outputs with no valid/ready handshake: the bus protocols carry their own pacing, so the block's edge has no back-pressure.

Top module: `dual_ctl_port`

## Requirements
- R1: After reset, register i holds RST_BASE+i (0xA0..0xA3 by default), on regs_o[8i+7:8i]. The block is in two-wire mode with spi_mode_o low and sda_oe low.
- R2: A two-wire address byte is acknowledged only if bits 7:2 equal 001000, bit 1 equals the level of sel_i, and bit 0 is R/W (1 = read). Any other address is not acknowledged, and the slave ignores the bus until the next START.
- R3: A two-wire write is an address byte with W, then a pointer byte, then data bytes. The slave acknowledges every byte, and each data byte is written to the register the pointer names.
- R4: In the pointer byte, bit 7 is the auto-increment flag and bits 6:0 are the register address. When the flag is set, the pointer steps by one after each data byte written or read, and wraps from register NREG-1 to register 0.
- R5: When the auto-increment flag is clear, the pointer stays put. Every data byte of a write lands in the same register, and every byte of a read returns that same register.
- R6: After a pointer write, a repeated START and an address byte with R=1 make the slave send the selected register MSB first. It sends a further byte for each master ACK. A master NACK ends the read and leaves SDA released.
- R7: Writes to an address at or above NREG are dropped, and reads from such an address return 0x00.
- R8: A STOP seen partway through a data byte ends the transfer and changes no register.
- R9: A falling edge on sel_i after reset sets spi_mode_o for good. From then on the block never drives SDA and ignores two-wire traffic.
- R10: In three-wire mode, while sel_i is low, cdin_i is sampled on each rising edge of cclk_i, MSB first. A frame is a chip byte of 0x20, a pointer byte, then data bytes, and the pointer follows R4 and R5. A frame whose chip byte is not 0x20 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Two-wire bus clock |
| sda_i | input | 1 | Two-wire data line as seen on the wire |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| sel_i | input | 1 | Address strap in two-wire mode, active-low chip select in three-wire mode |
| cclk_i | input | 1 | Three-wire serial clock |
| cdin_i | input | 1 | Three-wire serial data in |
| spi_mode_o | output | 1 | High once three-wire mode is latched |
| regs_o | output | NREG*8 | Register bank contents, register i at bits 8i+7:8i |

## Verification
Two-wire writes are driven with auto-increment both on and off. This separates a stepping pointer from a fixed one, and a burst of four bytes shows the wrap from the last register to register 0. Reads use ACK chains and a NACK, so the continue and stop paths differ in what appears on SDA. Address bytes with the wrong identifier or the wrong strap bit, an out-of-range pointer, and a byte cut short by a STOP each show whether ignored traffic leaves the registers alone. Three-wire frames with a valid chip byte, a bad chip byte and a clear increment flag, plus two-wire traffic sent after the switch, test that the mode latch holds and that the framing is correct.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  typedef enum logic [3:0] {
    TW_IDLE, TW_ADDR, TW_AACK, TW_PTR, TW_PACK,
    TW_WDAT, TW_WACK, TW_TX, TW_RACK
  } tw_state_t;
endpackage

// File: rtl/dcp_sync.sv
module dcp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end
  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcp_regbank.sv
module dcp_regbank #(
  parameter int NREG = 4,
  parameter logic [7:0] RST_BASE = 8'hA0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ptr_we,
  input  logic            wr_en,
  input  logic            adv,
  input  logic [7:0]      din,
  output logic [7:0]      rdata,
  output logic [NREG*8-1:0] regs_o
);
  localparam logic [6:0] LAST = 7'(NREG - 1);
  logic [6:0] ptr;
  logic       incr;
  logic [6:0] ptr_nx;
  assign ptr_nx = (ptr >= LAST) ? 7'd0 : ptr + 7'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      incr <= 1'b0;
    end else if (ptr_we) begin
      ptr  <= din[6:0];
      incr <= din[7];
    end else if ((wr_en || adv) && incr) begin
      ptr <= ptr_nx;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_BASE + 8'(g);
      else if (wr_en && ptr == 7'(g)) r <= din;
    end
    assign regs_o[g*8 +: 8] = r;
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (ptr == 7'(i)) rdata = regs_o[i*8 +: 8];
  end
endmodule

// File: rtl/dcp_twowire.sv
module dcp_twowire
  import dcp_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'b001000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       scl,
  input  logic       sda,
  input  logic       strap,
  input  logic [7:0] rdata,
  output logic       sda_oe,
  output logic       ptr_we,
  output logic       wr_en,
  output logic       adv,
  output logic [7:0] byte_o
);
  tw_state_t st;
  logic scl_q, sda_q, rw, mack;
  logic [3:0] cnt;
  logic [7:0] sh, txsh;
  logic scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
  assign byte_o   = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TW_IDLE; scl_q <= 1'b0; sda_q <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      cnt <= '0; sh <= '0; txsh <= '0; sda_oe <= 1'b0;
      ptr_we <= 1'b0; wr_en <= 1'b0; adv <= 1'b0;
    end else begin
      scl_q <= scl; sda_q <= sda;
      ptr_we <= 1'b0; wr_en <= 1'b0; adv <= 1'b0;
      if (!en) begin
        st <= TW_IDLE; sda_oe <= 1'b0;
      end else if (start_c) begin
        st <= TW_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= TW_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          TW_ADDR, TW_PTR, TW_WDAT: begin
            if (scl_rise && cnt < 4'd8) begin
              sh <= {sh[6:0], sda}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == TW_ADDR) begin
                if (sh[7:2] == DEV_ID && sh[1] == strap) begin
                  rw <= sh[0]; sda_oe <= 1'b1; st <= TW_AACK;
                end else st <= TW_IDLE;
              end else if (st == TW_PTR) begin
                ptr_we <= 1'b1; sda_oe <= 1'b1; st <= TW_PACK;
              end else begin
                wr_en <= 1'b1; sda_oe <= 1'b1; st <= TW_WACK;
              end
            end
          end
          TW_AACK, TW_RACK: begin
            if (scl_rise) mack <= ~sda;
            if (scl_fall) begin
              if ((st == TW_AACK && rw) || (st == TW_RACK && mack)) begin
                txsh <= rdata; sda_oe <= ~rdata[7]; adv <= 1'b1;
                cnt <= '0; st <= TW_TX;
              end else begin
                sda_oe <= 1'b0;
                st <= (st == TW_AACK) ? TW_PTR : TW_IDLE;
              end
            end
          end
          TW_PACK, TW_WACK: if (scl_fall) begin
            sda_oe <= 1'b0; st <= TW_WDAT;
          end
          TW_TX: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; st <= TW_RACK;
              end else begin
                txsh <= {txsh[6:0], 1'b0}; sda_oe <= ~txsh[6];
              end
            end
          end
          default: st <= TW_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcp_threewire.sv
module dcp_threewire #(
  parameter logic [5:0] DEV_ID = 6'b001000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cs_n,
  input  logic       cclk,
  input  logic       cdin,
  output logic       ptr_we,
  output logic       wr_en,
  output logic [7:0] byte_o
);
  localparam logic [7:0] CHIP_BYTE = {DEV_ID, 2'b00};
  logic cclk_q, drop;
  logic [2:0] cnt;
  logic [1:0] nb;
  logic [7:0] sh, nxt;

  assign nxt    = {sh[6:0], cdin};
  assign byte_o = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cclk_q <= 1'b0; drop <= 1'b0; cnt <= '0; nb <= '0; sh <= '0;
      ptr_we <= 1'b0; wr_en <= 1'b0;
    end else begin
      cclk_q <= cclk;
      ptr_we <= 1'b0; wr_en <= 1'b0;
      if (!en || cs_n) begin
        cnt <= '0; nb <= '0; drop <= 1'b0;
      end else if (cclk && !cclk_q) begin
        sh  <= nxt;
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          if (!drop) begin
            case (nb)
              2'd0:    drop   <= (nxt != CHIP_BYTE);
              2'd1:    ptr_we <= 1'b1;
              default: wr_en  <= 1'b1;
            endcase
          end
          if (nb != 2'd2) nb <= nb + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/dual_ctl_port.sv
module dual_ctl_port #(
  parameter int NREG = 4,
  parameter logic [7:0] RST_BASE = 8'hA0,
  parameter logic [5:0] DEV_ID = 6'b001000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              sel_i,
  input  logic              cclk_i,
  input  logic              cdin_i,
  output logic              spi_mode_o,
  output logic [NREG*8-1:0] regs_o
);
  logic scl_s, sda_s, sel_s, cclk_s, cdin_s, sel_q;
  logic i_ptr, i_wr, i_adv, s_ptr, s_wr, ptr_we, wr_en;
  logic [7:0] i_byte, s_byte, din, rdata;

  dcp_sync #(.W(5), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({scl_i, sda_i, sel_i, cclk_i, cdin_i}),
    .q({scl_s, sda_s, sel_s, cclk_s, cdin_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0; spi_mode_o <= 1'b0;
    end else begin
      sel_q <= sel_s;
      if (sel_q && !sel_s) spi_mode_o <= 1'b1;
    end
  end

  dcp_twowire #(.DEV_ID(DEV_ID)) u_tw (
    .clk(clk), .rst_n(rst_n), .en(!spi_mode_o), .scl(scl_s), .sda(sda_s),
    .strap(sel_s), .rdata(rdata), .sda_oe(sda_oe), .ptr_we(i_ptr),
    .wr_en(i_wr), .adv(i_adv), .byte_o(i_byte)
  );

  dcp_threewire #(.DEV_ID(DEV_ID)) u_3w (
    .clk(clk), .rst_n(rst_n), .en(spi_mode_o), .cs_n(sel_s), .cclk(cclk_s),
    .cdin(cdin_s), .ptr_we(s_ptr), .wr_en(s_wr), .byte_o(s_byte)
  );

  assign ptr_we = spi_mode_o ? s_ptr : i_ptr;
  assign wr_en  = spi_mode_o ? s_wr : i_wr;
  assign din    = spi_mode_o ? s_byte : i_byte;

  dcp_regbank #(.NREG(NREG), .RST_BASE(RST_BASE)) u_bank (
    .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .wr_en(wr_en),
    .adv(i_adv & ~spi_mode_o), .din(din), .rdata(rdata), .regs_o(regs_o)
  );
endmodule

// File: rtl/dual_ctl_port_chk.sv
module dual_ctl_port_chk #(
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          spi_mode_o,
  input logic [RW-1:0] regs_o,
  input logic          wr_en,
  input logic          scl_s,
  input logic          i_wr,
  input logic          s_wr
);
  a_r9_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode_o |=> spi_mode_o);
  a_r9_no_drive_in_spi: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode_o |=> !sda_oe);
  a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));
  a_r10_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({i_wr, s_wr}));
  a_r6_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind dual_ctl_port dual_ctl_port_chk #(.RW(NREG*8)) u_chk (.*);

// File: tb/dual_ctl_port_bench.sv
module dual_ctl_port_bench;
  localparam int CLK = 10;
  localparam int Q = 5 * CLK;
  localparam int NREG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, sel = 1'b1, cclk = 1'b0, cdin = 1'b0;
  logic sda_oe, spi_mode;
  logic [NREG*8-1:0] regs;
  wire sda_line = sda_m & ~sda_oe;
  int n_run = 0, n_fail = 0;

  always #(CLK/2) clk = ~clk;

  dual_ctl_port u_dual_ctl_port (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .sel_i(sel), .cclk_i(cclk), .cdin_i(cdin), .spi_mode_o(spi_mode), .regs_o(regs)
  );

  function automatic logic [7:0] rg(int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tw_start();
    sda_m = 1; #Q; scl = 1; #Q; sda_m = 0; #Q; scl = 0; #Q;
  endtask
  task automatic tw_stop();
    sda_m = 0; #Q; scl = 1; #Q; sda_m = 1; #Q;
  endtask
  task automatic tw_wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl = 1; #(2*Q); scl = 0; #Q;
    end
    sda_m = 1; #Q; scl = 1; #Q; ack = !sda_line; #Q; scl = 0; #Q;
  endtask
  task automatic tw_rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1; #Q; b[i] = sda_line; #Q; scl = 0; #Q;
    end
    sda_m = ~mack; #Q; scl = 1; #(2*Q); scl = 0; #Q; sda_m = 1;
  endtask
  task automatic tw_write(input logic [7:0] ptr, input logic [7:0] d[], string tag);
    bit a;
    tw_start();
    tw_wbyte(8'h22, a); chk(a, {tag, " addr ack"}, a, 1);
    tw_wbyte(ptr, a);   chk(a, {tag, " ptr ack"}, a, 1);
    foreach (d[k]) begin tw_wbyte(d[k], a); chk(a, {tag, " data ack"}, a, 1); end
    tw_stop();
  endtask
  task automatic tw_read(input logic [7:0] ptr, input logic [7:0] exp[], string tag);
    bit a; logic [7:0] b;
    tw_start(); tw_wbyte(8'h22, a); tw_wbyte(ptr, a);
    tw_start(); tw_wbyte(8'h23, a); chk(a, {tag, " read addr ack"}, a, 1);
    foreach (exp[k]) begin
      tw_rbyte(k != exp.size() - 1, b);
      chk(b == exp[k], {tag, " read data"}, b, exp[k]);
    end
    tw_stop(); #Q;
    chk(!sda_oe && sda_line, {tag, " SDA released"}, sda_oe, 0);
  endtask
  task automatic tw_byte3(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      cdin = b[i]; #Q; cclk = 1; #Q; cclk = 0;
    end
  endtask
  task automatic spi_frame(input logic [7:0] f[]);
    sel = 0; #(2*Q);
    foreach (f[k]) tw_byte3(f[k]);
    #Q; sel = 1; #(2*Q);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) chk(rg(i) == 8'hA0 + i, "R1 reset value", rg(i), 8'hA0 + i);
    chk(!spi_mode && !sda_oe, "R1 mode/SDA idle", {spi_mode, sda_oe}, 0);
  endtask
  task automatic t_addr_mismatch();
    bit a;
    tw_start(); tw_wbyte(8'h20, a); tw_stop();
    chk(!a, "R2 strap bit mismatch nack", a, 0);
    tw_start(); tw_wbyte(8'h42, a); tw_wbyte(8'h81, a); tw_wbyte(8'h5C, a); tw_stop();
    chk(!a, "R2 wrong id ignored", a, 0);
    chk(rg(1) == 8'hA1, "R2 no write on mismatch", rg(1), 8'hA1);
  endtask
  task automatic t_write_incr();
    tw_write(8'h81, '{8'h11, 8'h22, 8'h33, 8'h44}, "R3");
    chk(rg(1) == 8'h11, "R3 reg1", rg(1), 8'h11);
    chk(rg(2) == 8'h22, "R4 step reg2", rg(2), 8'h22);
    chk(rg(3) == 8'h33, "R4 step reg3", rg(3), 8'h33);
    chk(rg(0) == 8'h44, "R4 wrap to reg0", rg(0), 8'h44);
  endtask
  task automatic t_write_fixed();
    tw_write(8'h02, '{8'h55, 8'h66}, "R5");
    chk(rg(2) == 8'h66, "R5 same reg", rg(2), 8'h66);
    chk(rg(3) == 8'h33, "R5 neighbour kept", rg(3), 8'h33);
  endtask
  task automatic t_reads();
    tw_read(8'h83, '{8'h33, 8'h44, 8'h11}, "R6 incr read wrap");
    tw_read(8'h01, '{8'h11, 8'h11}, "R5 fixed read");
  endtask
  task automatic t_unimpl();
    tw_write(8'h05, '{8'h77}, "R7");
    chk(regs == 32'h3366_1144, "R7 write dropped", regs, 32'h3366_1144);
    tw_read(8'h05, '{8'h00}, "R7 read zero");
  endtask
  task automatic t_abort();
    bit a;
    tw_start(); tw_wbyte(8'h22, a); tw_wbyte(8'h01, a);
    for (int i = 0; i < 4; i++) begin sda_m = 0; #Q; scl = 1; #(2*Q); scl = 0; #Q; end
    tw_stop(); #Q;
    chk(rg(1) == 8'h11, "R8 abort keeps reg1", rg(1), 8'h11);
  endtask
  task automatic t_spi();
    bit a;
    spi_frame('{8'h20, 8'h82, 8'h9A, 8'h9B});
    chk(spi_mode, "R9 mode latched", spi_mode, 1);
    chk(rg(2) == 8'h9A, "R10 reg2", rg(2), 8'h9A);
    chk(rg(3) == 8'h9B, "R10 reg3", rg(3), 8'h9B);
    spi_frame('{8'h21, 8'h80, 8'h01});
    chk(rg(0) == 8'h44, "R10 bad chip byte", rg(0), 8'h44);
    spi_frame('{8'h20, 8'h01, 8'h5A, 8'h5B});
    chk(rg(1) == 8'h5B, "R10 fixed pointer", rg(1), 8'h5B);
    chk(rg(2) == 8'h9A, "R10 fixed neighbour", rg(2), 8'h9A);
    tw_start(); tw_wbyte(8'h22, a); tw_wbyte(8'h80, a); tw_wbyte(8'hEE, a); tw_stop();
    chk(!a && spi_mode, "R9 two-wire ignored", a, 0);
    chk(rg(0) == 8'h44, "R9 no two-wire write", rg(0), 8'h44);
  endtask

  initial begin
    #(200000 * CLK);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4*CLK + 2); rst_n = 1; #(4*CLK);
    t_reset();
    t_addr_mismatch();
    t_write_incr();
    t_write_fixed();
    t_reads();
    t_unimpl();
    t_abort();
    t_spi();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule